// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2^IDX_W small state entries, and each entry is selected by a slice of the branch address. On the lookup side, fetch presents a PC and receives a taken or not-taken guess in the same cycle, through a combinational read of the table. On the update side, the execution stage reports a resolved branch PC and its real outcome under a valid strobe. The selected entry is then moved toward that outcome at the next clock edge. Branches that map to the same slice share an entry, and the design accepts that aliasing.

A compile-time parameter picks the entry type. With ENTRY_BITS = 1, an entry only remembers the last outcome. With ENTRY_BITS = 2, an entry is a saturating up/down counter. In the counter, bit 1 is the predicted direction and bit 0 supplies hysteresis, so one surprise outcome does not flip a strongly biased branch. Reset puts every entry on the not-taken side, one step from the boundary.

Top module: `bimodal_predictor`

## Requirements
- R1: The entry index is PC bits [IDX_W+1:2]. Two PCs that differ only in bits [1:0], or only above bit IDX_W+1, select the same entry.
- R2: After a synchronous reset, every lookup predicts not taken (lk_taken = 0). In 2-bit mode each entry resets to 01, so one taken update makes that entry predict taken.
- R3: In 1-bit mode the prediction equals the outcome of the most recent valid update to the same index (1 = taken, 0 = not taken).
- R4: In 2-bit mode the prediction is the counter MSB. Encodings 00 (strong) and 01 (weak) predict not taken; 10 (weak) and 11 (strong) predict taken.
- R5: In 2-bit mode a taken update adds one to the counter and saturates at 11. After three or more taken updates, a single not-taken update still leaves the entry predicting taken.
- R6: In 2-bit mode a not-taken update subtracts one from the counter and saturates at 00. After two or more not-taken updates from reset, a single taken update still leaves the entry predicting not taken.
- R7: When up_valid is 0, the table is unchanged whatever up_pc and up_taken carry.
- R8: When a lookup and a valid update select the same index in one cycle, the lookup returns the prediction from before that update. The new value is visible from the following cycle.
- R9: For a four-iteration loop branch (taken, taken, taken, not taken) that is entered again, the 2-bit mode mispredicts only the exit on each later pass. The 1-bit mode mispredicts both the exit and the first iteration.
- R10: An update changes only the entry it indexes. Lookups that select other indices are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the table updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of all entries |
| lk_pc | input | PC_W | PC of the branch being looked up |
| lk_taken | output | 1 | Predicted direction for lk_pc (1 = taken), same cycle |
| up_valid | input | 1 | Qualifies one update in this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch (1 = taken) |

## Verification
The clocked properties assume that the update inputs are meaningful only while up_valid is high. They also assume that lk_pc is held across a cycle whenever a property compares the prediction in one cycle with the prediction in the next; each property requires this explicitly through $stable(lk_pc). The stimulus drives lk_pc, up_valid, up_pc and up_taken once per cycle, on the falling edge. It mixes PCs that alias through the ignored address bits, PCs that hit the same index as the update in that cycle, and cycles with the strobe low but garbage on the other update inputs. A behavioural model tracks every entry as an integer and predicts both entry types on every cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;
  // Two-bit counter states; bit 1 is the direction, bit 0 the hysteresis.
  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_state_t;
endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  // Instructions are word aligned, so the two lowest bits carry no information.
  logic unused_bits;
  assign unused_bits = ^{pc[PC_W-1:IDX_W+2], pc[1:0]};
  assign idx = pc[IDX_W+1:2];
endmodule

// File: rtl/bp_next.sv
module bp_next
  import bp_pkg::*;
#(
  parameter int ENTRY_BITS = 2
) (
  input  logic [ENTRY_BITS-1:0] cur,
  input  logic                  taken,
  output logic [ENTRY_BITS-1:0] nxt
);
  generate
    if (ENTRY_BITS == 1) begin : g_last
      logic unused_cur;
      assign unused_cur = cur[0];
      assign nxt = taken;
    end else begin : g_ctr
      ctr_state_t st;
      assign st = ctr_state_t'(cur);
      always_comb begin
        nxt = cur;
        case (st)
          CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT   : CTR_STRONG_NT;
          CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T    : CTR_STRONG_NT;
          CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T  : CTR_WEAK_NT;
          CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T  : CTR_WEAK_T;
          default:       nxt = cur;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/bp_table.sv
module bp_table #(
  parameter int IDX_W      = 6,
  parameter int ENTRY_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [IDX_W-1:0]      rd_a_idx,
  output logic [ENTRY_BITS-1:0] rd_a_val,
  input  logic [IDX_W-1:0]      rd_b_idx,
  output logic [ENTRY_BITS-1:0] rd_b_val,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [ENTRY_BITS-1:0] wr_val
);
  localparam int DEPTH = 1 << IDX_W;
  // Reset value: one step below the taken boundary (01 for counters, 0 for 1-bit).
  localparam logic [ENTRY_BITS-1:0] INIT = ENTRY_BITS'((1 << (ENTRY_BITS - 1)) - 1);

  logic [ENTRY_BITS-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_val;
    end
  end

  // Asynchronous reads see the contents from before this cycle's write.
  assign rd_a_val = mem[rd_a_idx];
  assign rd_b_val = mem[rd_b_idx];
endmodule

// File: rtl/bimodal_predictor.sv
module bimodal_predictor #(
  parameter int PC_W       = 32,
  parameter int IDX_W      = 6,
  parameter int ENTRY_BITS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  logic [IDX_W-1:0]      lk_idx, up_idx;
  logic [ENTRY_BITS-1:0] lk_val, up_cur, up_nxt;

  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) i_lk_index (.pc(lk_pc), .idx(lk_idx));
  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) i_up_index (.pc(up_pc), .idx(up_idx));

  bp_table #(.IDX_W(IDX_W), .ENTRY_BITS(ENTRY_BITS)) i_table (
    .clk      (clk),
    .rst      (rst),
    .rd_a_idx (lk_idx),
    .rd_a_val (lk_val),
    .rd_b_idx (up_idx),
    .rd_b_val (up_cur),
    .wr_en    (up_valid),
    .wr_idx   (up_idx),
    .wr_val   (up_nxt)
  );

  bp_next #(.ENTRY_BITS(ENTRY_BITS)) i_next (
    .cur   (up_cur),
    .taken (up_taken),
    .nxt   (up_nxt)
  );

  assign lk_taken = lk_val[ENTRY_BITS-1];
endmodule

// File: rtl/bimodal_predictor_chk.sv
module bimodal_predictor_chk #(
  parameter int PC_W       = 32,
  parameter int IDX_W      = 6,
  parameter int ENTRY_BITS = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] lk_pc,
  input logic            lk_taken,
  input logic            up_valid,
  input logic [PC_W-1:0] up_pc,
  input logic            up_taken
);
  logic [IDX_W-1:0] c_lk_idx, c_up_idx;
  logic unused_chk;
  assign c_lk_idx = lk_pc[IDX_W+1:2];
  assign c_up_idx = up_pc[IDX_W+1:2];
  assign unused_chk = ^{lk_pc[PC_W-1:IDX_W+2], lk_pc[1:0], up_pc[PC_W-1:IDX_W+2], up_pc[1:0]};

  // R2: first cycle out of reset predicts not taken
  a_r2_reset_not_taken: assert property (@(posedge clk) ($past(rst) && !rst) |-> !lk_taken);

  // R7: no valid update and a held lookup PC keep the prediction
  a_r7_idle_keeps: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(up_valid) && $stable(lk_pc)) |-> $stable(lk_taken));

  generate
    if (ENTRY_BITS == 1) begin : g_chk1
      // R3: prediction follows the last outcome written to that index
      a_r3_last_outcome: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(up_valid) && $stable(lk_pc) && (c_lk_idx == $past(c_up_idx)))
        |-> (lk_taken == $past(up_taken)));
    end else begin : g_chk2
      // R5: taken update on a taken-predicting entry keeps it taken
      a_r5_sat_taken: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(up_valid && up_taken && lk_taken && (c_lk_idx == c_up_idx))
         && $stable(lk_pc)) |-> lk_taken);
      // R6: not-taken update on a not-taken entry keeps it not taken
      a_r6_sat_not_taken: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(up_valid && !up_taken && !lk_taken && (c_lk_idx == c_up_idx))
         && $stable(lk_pc)) |-> !lk_taken);
      // R4: a single update moves the direction at most toward its outcome
      a_r4_toward_outcome: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(up_valid) && $stable(lk_pc) && (c_lk_idx == $past(c_up_idx))
         && (lk_taken != $past(lk_taken))) |-> (lk_taken == $past(up_taken)));
    end
  endgenerate
endmodule

bind bimodal_predictor bimodal_predictor_chk #(
  .PC_W(PC_W), .IDX_W(IDX_W), .ENTRY_BITS(ENTRY_BITS)
) i_chk (.*);

// File: tb/test_bimodal_predictor.sv
`timescale 1ns/1ps
module test_bimodal_predictor;
  localparam int IDX_W = 6;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [31:0] BASE = 32'h4001_0100;
  localparam logic [31:0] ALIAS = 32'h1 << (IDX_W + 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] lk_pc = '0, up_pc = '0;
  logic up_valid = 1'b0, up_taken = 1'b0;
  logic lk2, lk1;

  int tests = 0, fails = 0;
  int m2 [DEPTH];
  int m1 [DEPTH];
  bit last2, last1;
  bit done = 0;

  always #10 clk = ~clk;

  bimodal_predictor #(.PC_W(32), .IDX_W(IDX_W), .ENTRY_BITS(2)) i_bimodal_predictor (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk2),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  bimodal_predictor #(.PC_W(32), .IDX_W(IDX_W), .ENTRY_BITS(1)) i_bimodal_predictor_1b (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk1),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  function automatic int ix(input logic [31:0] pc);
    return int'((pc >> 2) & (DEPTH - 1));
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One cycle: drive, compare both predictions to the model, then commit the update.
  task automatic cyc(input logic [31:0] lpc, input bit uv, input logic [31:0] upc,
                     input bit ut, input string tag);
    @(negedge clk);
    lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
    #1;
    last2 = lk2; last1 = lk1;
    check({tag, " 2b"}, lk2, m2[ix(lpc)] >= 2);
    check({tag, " 1b"}, lk1, m1[ix(lpc)] == 1);
    @(posedge clk);
    if (uv) begin
      if (ut) begin
        if (m2[ix(upc)] < 3) m2[ix(upc)]++;
        m1[ix(upc)] = 1;
      end else begin
        if (m2[ix(upc)] > 0) m2[ix(upc)]--;
        m1[ix(upc)] = 0;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; up_valid = 1'b0;
    repeat (3) @(posedge clk);
    for (int i = 0; i < DEPTH; i++) begin m2[i] = 1; m1[i] = 0; end
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lfsr;
    int miss2, miss1;
    do_reset();

    // R2: reset state predicts not taken everywhere
    for (int i = 0; i < 4; i++) cyc(BASE + 32'(i * 20), 1'b0, 32'h0, 1'b1, "R2 reset");
    // R2: one taken from 01 flips the 2-bit entry to taken
    cyc(BASE, 1'b1, BASE, 1'b1, "R2 first taken");
    cyc(BASE, 1'b0, BASE, 1'b0, "R2 after one taken");
    check("R2 weak start", last2, 1'b1);

    // R1: aliasing through ignored low bits and high bits
    cyc(BASE | 32'h3, 1'b0, 32'h0, 1'b0, "R1 low bits alias");
    check("R1 low alias", last2, 1'b1);
    cyc(BASE + ALIAS, 1'b0, 32'h0, 1'b0, "R1 high bits alias");
    check("R1 high alias", last1, 1'b1);
    // R10: neighbouring index unaffected
    cyc(BASE + 32'h4, 1'b0, 32'h0, 1'b0, "R10 neighbour");
    check("R10 neighbour 2b", last2, 1'b0);

    // R7: strobe low with garbage payload changes nothing
    cyc(BASE + 32'h8, 1'b0, BASE + 32'h8, 1'b1, "R7 ignored update");
    cyc(BASE + 32'h8, 1'b0, BASE + 32'h8, 1'b1, "R7 ignored update");
    check("R7 still not taken", last2, 1'b0);
    check("R7 still not taken 1b", last1, 1'b0);

    // R8: same-cycle lookup sees old value, next cycle the new one
    cyc(BASE + 32'hC, 1'b1, BASE + 32'hC, 1'b1, "R8 same cycle");
    check("R8 old value", last1, 1'b0);
    cyc(BASE + 32'hC, 1'b0, 32'h0, 1'b0, "R8 next cycle");
    check("R8 new value", last1, 1'b1);

    // R5: saturate high, then one not-taken still predicts taken
    for (int i = 0; i < 4; i++) cyc(BASE + 32'h10, 1'b1, BASE + 32'h10, 1'b1, "R5 climb");
    cyc(BASE + 32'h10, 1'b1, BASE + 32'h10, 1'b0, "R5 one not taken");
    cyc(BASE + 32'h10, 1'b0, 32'h0, 1'b0, "R5 hysteresis");
    check("R5 still taken", last2, 1'b1);
    check("R3 1b follows last", last1, 1'b0);
    cyc(BASE + 32'h10, 1'b1, BASE + 32'h10, 1'b0, "R4 weak taken to weak nt");
    cyc(BASE + 32'h10, 1'b0, 32'h0, 1'b0, "R4 weak not taken");
    check("R4 01 predicts nt", last2, 1'b0);

    // R6: saturate low, then one taken still predicts not taken
    for (int i = 0; i < 3; i++) cyc(BASE + 32'h14, 1'b1, BASE + 32'h14, 1'b0, "R6 fall");
    cyc(BASE + 32'h14, 1'b1, BASE + 32'h14, 1'b1, "R6 one taken");
    cyc(BASE + 32'h14, 1'b0, 32'h0, 1'b0, "R6 hysteresis");
    check("R6 still not taken", last2, 1'b0);
    check("R3 1b last taken", last1, 1'b1);

    // R9: four-iteration loop entered three times
    for (int pass = 0; pass < 3; pass++) begin
      miss2 = 0; miss1 = 0;
      for (int it = 0; it < 4; it++) begin
        cyc(BASE + 32'h40, 1'b1, BASE + 32'h40, (it != 3), "R9 loop");
        if (last2 != (it != 3)) miss2++;
        if (last1 != (it != 3)) miss1++;
      end
      if (pass > 0) begin
        check_int("R9 2b misses per pass", miss2, 1);
        check_int("R9 1b misses per pass", miss1, 2);
      end
    end

    // Mixed traffic with aliasing and same-index collisions
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = BASE + (32'(lfsr[3:0]) << 2) + (lfsr[4] ? ALIAS : 32'h0) + 32'(lfsr[9:8]);
      b = lfsr[7] ? a : BASE + (32'(lfsr[14:11]) << 2);
      cyc(a, lfsr[5], b, lfsr[6], "R1 R3 R4 R8 R10 mixed");
    end

    // R2: reset again clears learned state
    do_reset();
    cyc(BASE + 32'h10, 1'b0, 32'h0, 1'b0, "R2 re-reset");
    check("R2 re-reset 1b", last1, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule